// File: doc/BRIEF.md
# Dadda Tree Unsigned Multiplier

This block multiplies two unsigned N-bit operands in a single combinational path and returns the full 2N-bit product. The AND of every operand bit pair forms a partial-product matrix. Bit pair (i, j) lands in column i+j and carries weight 2^(i+j).

The matrix is squeezed column by column through a chain of reduction stages. Each stage has a target height taken from the series 2, 3, 4, 6, 9, 13, …, where each term is the floor of 1.5 times the one before it. The first stage uses the largest term that is still below N, and each later stage uses the next smaller term, down to 2. Within a stage the columns are visited from the least significant upward, and carries that arrive from the right are counted. A column gets only enough full adders (3-to-2) to reach the target, plus one half adder (2-to-2) when a single extra bit remains. When two rows are left, a ripple carry adder merges them into the product.

With N = 8 the stage targets are 6, 4, 3 and 2. The tree then holds 35 full adders and 7 half adders. The block has no clock, no reset and no handshake: the product settles one combinational delay after the operands change. Any registering is left to the surrounding pipeline.

Top module: `dadda_mul`

## Requirements
- R1: For every pair of unsigned operands, `product` equals op_a × op_b in full 2N-bit precision, with no truncation.
- R2: If either operand is zero, `product` is all zeros.
- R3: Bit 0 of `product` equals op_a[0] AND op_b[0], so the product is odd exactly when both operands are odd.
- R4: The product never exceeds (2^N − 1)²; both operands all ones give exactly that value (0xFE01 for N = 8).
- R5: Every reduction stage preserves the weighted sum of its matrix bits (Σ bit · 2^column).
- R6: After the last reduction stage, each column holds no more than two bits; positions 2 and above are zero.
- R7: An operand of 1 returns the other operand zero-extended to 2N bits.
- R8: An operand equal to 2^k returns the other operand shifted left by k places.
- R9: The weighted sum of the generated partial-product matrix equals op_a × op_b.
- R10: Swapping the two operands leaves `product` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First unsigned operand |
| op_b | input | N | Second unsigned operand |
| product | output | 2N | Unsigned product op_a × op_b |

## Verification
Assertions inside the RTL check each internal boundary whenever the operands change:
- the matrix value against the arithmetic product,
- the conservation of weighted value across each reduction stage,
- the two-row shape of the final matrix,
- the exactness, zero behaviour, low bit and upper bound of the output.

Some properties can only be seen at the pins through the bench's directed scenarios. These are identity, power-of-two shifting, operand symmetry and the all-ones corner. The bench also sweeps every operand pair at the default width, so every carry-chain pattern through the tree and the final adder is exercised.

// File: rtl/dadda_mul_pkg.sv
`timescale 1ns/1ps
package dadda_mul_pkg;

  // Upper bound on product columns handled by the elaboration helpers.
  localparam int MAX_COLS = 128;

  // Selectors for dadda_info().
  localparam int INFO_HEIGHT   = 0;
  localparam int INFO_FULL     = 1;
  localparam int INFO_HALF     = 2;
  localparam int INFO_CARRY_IN = 3;

  // Number of reduction stages: count of series terms strictly below n.
  function automatic int dadda_stage_count(input int n);
    int cnt;
    int d;
    cnt = 0;
    d   = 2;
    while (d < n) begin
      cnt = cnt + 1;
      d   = (d * 3) / 2;
    end
    return cnt;
  endfunction

  // idx-th term of the height series (idx = 1 gives 2).
  function automatic int dadda_limit(input int idx);
    int d;
    d = 2;
    for (int i = 1; i < idx; i++) d = (d * 3) / 2;
    return d;
  endfunction

  // Bits in column c of the raw n x n partial-product matrix.
  function automatic int dadda_col_depth(input int n, input int c);
    int r;
    if (c < n)               r = c + 1;
    else if (c < 2 * n - 1)  r = 2 * n - 1 - c;
    else                     r = 0;
    return r;
  endfunction

  // Replays the reduction schedule up to stage s and reports, for column c
  // at the entry of that stage, its height, its full/half adder counts or
  // the number of carries it receives from column c-1.
  function automatic int dadda_info(input int n, input int s, input int c, input int sel);
    int h   [MAX_COLS];
    int nxt [MAX_COLS];
    int carry;
    int excess;
    int nfa;
    int nha;
    int lim;
    int res;
    res = 0;
    for (int i = 0; i < MAX_COLS; i++) begin
      h[i]   = dadda_col_depth(n, i);
      nxt[i] = 0;
    end
    for (int st = 0; st <= s; st++) begin
      lim   = dadda_limit(dadda_stage_count(n) - st);
      carry = 0;
      for (int i = 0; i < 2 * n; i++) begin
        excess = h[i] + carry - lim;
        nfa    = (excess > 0) ? excess / 2 : 0;
        nha    = (excess > 0) ? excess % 2 : 0;
        if (st == s && i == c) begin
          case (sel)
            INFO_HEIGHT:   res = h[i];
            INFO_FULL:     res = nfa;
            INFO_HALF:     res = nha;
            INFO_CARRY_IN: res = carry;
            default:       res = 0;
          endcase
        end
        nxt[i] = h[i] - 2 * nfa - nha + carry;
        carry  = nfa + nha;
      end
      for (int i = 0; i < 2 * n; i++) h[i] = nxt[i];
    end
    return res;
  endfunction

endpackage

// File: rtl/dadda_mul_matrix.sv
`timescale 1ns/1ps
module dadda_mul_matrix import dadda_mul_pkg::*; #(
  parameter int N = 8
) (
  input  logic [N-1:0]             op_a,
  input  logic [N-1:0]             op_b,
  output logic [2*N-1:0][N-1:0]    pp
);
  localparam int W = 2 * N;

  // Column c, slot k holds a[i] & b[c-i]; slots are packed from 0 upward.
  for (genvar c = 0; c < W; c++) begin : g_col
    localparam int DEPTH = dadda_col_depth(N, c);
    localparam int FIRST = (c < N) ? 0 : c - N + 1;
    for (genvar k = 0; k < N; k++) begin : g_slot
      if (k < DEPTH) begin : g_and
        assign pp[c][k] = op_a[FIRST + k] & op_b[c - FIRST - k];
      end else begin : g_empty
        assign pp[c][k] = 1'b0;
      end
    end
  end

  function automatic logic [W-1:0] weigh(input logic [W-1:0][N-1:0] m);
    logic [W-1:0] acc;
    acc = '0;
    for (int c = 0; c < W; c++)
      for (int k = 0; k < N; k++)
        acc = acc + (W'(m[c][k]) << c);
    return acc;
  endfunction

  always_comb begin
    if (!$isunknown({op_a, op_b})) begin
      // R9: matrix carries the full arithmetic value of the product
      assert_matrix_value_R9: assert (weigh(pp) == W'(op_a) * W'(op_b))
        else $error("matrix weight %h differs from %h", weigh(pp), W'(op_a) * W'(op_b));
    end
  end

endmodule

// File: rtl/dadda_mul_stage.sv
`timescale 1ns/1ps
module dadda_mul_stage import dadda_mul_pkg::*; #(
  parameter int N     = 8,
  parameter int STAGE = 0
) (
  input  logic [2*N-1:0][N-1:0] col_in,
  output logic [2*N-1:0][N-1:0] col_out
);
  localparam int W = 2 * N;

  // Output column layout, low slots first:
  //   carries from column c-1 | sums of this column's adders | untouched bits | zeros
  for (genvar c = 0; c < W; c++) begin : g_col
    localparam int HIN  = dadda_info(N, STAGE, c, INFO_HEIGHT);
    localparam int NF   = dadda_info(N, STAGE, c, INFO_FULL);
    localparam int NH   = dadda_info(N, STAGE, c, INFO_HALF);
    localparam int CIN  = dadda_info(N, STAGE, c, INFO_CARRY_IN);
    localparam int NC   = NF + NH;
    localparam int BASE = 3 * NF + 2 * NH;
    localparam int NP   = HIN - BASE;

    for (genvar f = 0; f < N; f++) begin : g_ctr
      if (f < NF) begin : g_full
        logic [1:0] fsum;
        assign fsum = {1'b0, col_in[c][3*f]} + {1'b0, col_in[c][3*f+1]}
                    + {1'b0, col_in[c][3*f+2]};
        assign col_out[c][CIN + f] = fsum[0];
        if (c + 1 < W) begin : g_carry
          assign col_out[c+1][f] = fsum[1];
        end
      end else if (f < NC) begin : g_half
        localparam int HB = 3 * NF + 2 * (f - NF);
        assign col_out[c][CIN + f] = col_in[c][HB] ^ col_in[c][HB+1];
        if (c + 1 < W) begin : g_carry
          assign col_out[c+1][f] = col_in[c][HB] & col_in[c][HB+1];
        end
      end
    end

    for (genvar k = 0; k < N; k++) begin : g_slot
      if (k >= CIN + NC && k < CIN + NC + NP) begin : g_pass
        assign col_out[c][k] = col_in[c][BASE + k - CIN - NC];
      end else if (k >= CIN + NC + NP) begin : g_zero
        assign col_out[c][k] = 1'b0;
      end
    end
  end

  function automatic logic [W-1:0] weigh(input logic [W-1:0][N-1:0] m);
    logic [W-1:0] acc;
    acc = '0;
    for (int c = 0; c < W; c++)
      for (int k = 0; k < N; k++)
        acc = acc + (W'(m[c][k]) << c);
    return acc;
  endfunction

  always_comb begin
    if (!$isunknown(col_in)) begin
      // R5: counters move weight between columns but never create or lose it
      assert_stage_value_R5: assert (weigh(col_in) == weigh(col_out))
        else $error("stage %0d weight %h became %h", STAGE, weigh(col_in), weigh(col_out));
    end
  end

endmodule

// File: rtl/dadda_mul_cpa.sv
`timescale 1ns/1ps
module dadda_mul_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] row_x,
  input  logic [W-1:0] row_y,
  output logic [W-1:0] sum
);
  logic [W-1:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = row_x[i] ^ row_y[i] ^ carry[i];
    if (i < W - 1) begin : g_next
      assign carry[i+1] = (row_x[i] & row_y[i]) | (carry[i] & (row_x[i] ^ row_y[i]));
    end
  end

endmodule

// File: rtl/dadda_mul.sv
`timescale 1ns/1ps
module dadda_mul import dadda_mul_pkg::*; #(
  parameter int N = 8
) (
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] product
);
  localparam int W      = 2 * N;
  localparam int STAGES = dadda_stage_count(N);
  localparam logic [W-1:0] MAX_PRODUCT =
    {{N{1'b0}}, {N{1'b1}}} * {{N{1'b0}}, {N{1'b1}}};

  logic [W-1:0][N-1:0] level [STAGES+1];
  logic [W-1:0]        row_x;
  logic [W-1:0]        row_y;
  logic                extra_bits;

  dadda_mul_matrix #(.N(N)) u_matrix (
    .op_a (op_a),
    .op_b (op_b),
    .pp   (level[0])
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    dadda_mul_stage #(.N(N), .STAGE(s)) u_stage (
      .col_in  (level[s]),
      .col_out (level[s+1])
    );
  end

  for (genvar c = 0; c < W; c++) begin : g_rows
    assign row_x[c] = level[STAGES][c][0];
    assign row_y[c] = level[STAGES][c][1];
  end

  dadda_mul_cpa #(.W(W)) u_cpa (
    .row_x (row_x),
    .row_y (row_y),
    .sum   (product)
  );

  always_comb begin
    extra_bits = 1'b0;
    for (int c = 0; c < W; c++)
      for (int k = 2; k < N; k++)
        extra_bits = extra_bits | level[STAGES][c][k];
  end

  always_comb begin
    if (!$isunknown({op_a, op_b})) begin
      assert_product_R1: assert (product == W'(op_a) * W'(op_b))
        else $error("product %h for %h x %h", product, op_a, op_b);
      assert_zero_R2: assert (!((op_a == '0) || (op_b == '0)) || (product == '0))
        else $error("zero operand gave %h", product);
      assert_lsb_R3: assert (product[0] == (op_a[0] & op_b[0]))
        else $error("product bit 0 wrong");
      assert_bound_R4: assert (product <= MAX_PRODUCT)
        else $error("product %h above bound", product);
      assert_two_rows_R6: assert (extra_bits == 1'b0)
        else $error("final matrix taller than two rows");
    end
  end

endmodule

// File: tb/dadda_mul_tb_top.sv
`timescale 1ns/1ps
module dadda_mul_tb_top;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] op_a = '0;
  logic [N-1:0] op_b = '0;
  logic [W-1:0] product;
  int           checks = 0;
  int           fails = 0;
  bit           finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  dadda_mul #(.N(N)) dut_i (
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Inputs change just after a rising edge, results are read at the falling edge.
  task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b);
    @(posedge clk);
    op_a = a;
    op_b = b;
    @(negedge clk);
  endtask

  task automatic t_reset_idle();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2", "idle inputs during reset", product, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_zero_operands();
    logic [N-1:0] vals [4] = '{8'h00, 8'h01, 8'h5A, 8'hFF};
    foreach (vals[i]) begin
      drive(8'h00, vals[i]);
      check("R2", $sformatf("0 x %h", vals[i]), product, '0);
      drive(vals[i], 8'h00);
      check("R2", $sformatf("%h x 0", vals[i]), product, '0);
    end
  endtask

  task automatic t_low_bit();
    for (int i = 0; i < 16; i++) begin
      logic [N-1:0] a;
      logic [N-1:0] b;
      a = N'(i * 37 + 3);
      b = N'(i * 91 + (i % 2));
      drive(a, b);
      check("R3", $sformatf("bit0 of %h x %h", a, b), W'(product[0]), W'(a[0] & b[0]));
    end
  endtask

  task automatic t_all_ones();
    drive(8'hFF, 8'hFF);
    check("R4", "all ones", product, 16'hFE01);
    drive(8'hFF, 8'hFE);
    check("R4", "ff x fe", product, 16'hFD02);
  endtask

  task automatic t_identity();
    logic [N-1:0] vals [5] = '{8'h00, 8'h01, 8'h80, 8'hA5, 8'hFF};
    foreach (vals[i]) begin
      drive(8'h01, vals[i]);
      check("R7", $sformatf("1 x %h", vals[i]), product, W'(vals[i]));
      drive(vals[i], 8'h01);
      check("R7", $sformatf("%h x 1", vals[i]), product, W'(vals[i]));
    end
  endtask

  task automatic t_power_of_two();
    for (int k = 0; k < N; k++) begin
      drive(N'(1 << k), 8'hB7);
      check("R8", $sformatf("2^%0d x b7", k), product, W'(8'hB7) << k);
      drive(8'h6D, N'(1 << k));
      check("R8", $sformatf("6d x 2^%0d", k), product, W'(8'h6D) << k);
    end
  endtask

  task automatic t_commute();
    for (int i = 0; i < 12; i++) begin
      logic [N-1:0] a;
      logic [N-1:0] b;
      logic [W-1:0] first;
      a = N'(i * 53 + 17);
      b = N'(255 - i * 29);
      drive(a, b);
      first = product;
      drive(b, a);
      check("R10", $sformatf("%h x %h swapped", a, b), product, first);
    end
  endtask

  // R1 exhaustive; also exposes stage (R5, R6) and matrix (R9) faults at the pins
  task automatic t_exhaustive();
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        drive(N'(a), N'(b));
        check("R1,R5,R6,R9", $sformatf("%h x %h", a, b), product, W'(a * b));
      end
    end
  endtask

  initial begin
    t_reset_idle();
    t_zero_operands();
    t_low_bit();
    t_all_ones();
    t_identity();
    t_power_of_two();
    t_commute();
    t_exhaustive();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule